// File: doc/BRIEF.md
# Signed Integer to Single-Precision Converter with Double-Format Output

This block takes a 64-bit signed two's-complement integer and produces the nearest value that single precision can represent, chosen under one of four rounding modes. The rounded value is re-encoded as a 64-bit double-precision word. The exponent is rebiased for the double format, and the 24-bit significand is widened with zero bits. A downstream unit can store the result directly in a double-width register. That result also remains exactly representable as a single-precision value.

The datapath runs in these steps, all in one combinational pass:

1. Take the magnitude of the input.
2. Count the leading zeros.
3. Shift the magnitude left until its leading one sits in the top bit.
4. Round to 24 significant bits.
5. Adjust the exponent if rounding carried out of the significand.
6. Pack the double-format word.

One register stage captures the result, the status flags and a class code on the clock edge after a valid strobe. The output valid flag follows the input strobe by exactly one clock. An accumulating inexact status bit records whether any conversion since reset lost precision.

Top module: `i2s_convert`

## Requirements
- R1: A nonzero input whose magnitude fits in 24 significant bits converts exactly. The output word holds the sign in bit 63, the exponent biased by 1023 in bits 62..52, and the fraction in bits 51..0. The low 29 fraction bits are always zero.
- R2: Mode 2'b00 rounds to nearest. When the discarded part is exactly half a unit in the last place, it rounds to the even significand.
- R3: Mode 2'b01 truncates toward zero and never increments the significand.
- R4: Mode 2'b10 rounds toward +infinity and mode 2'b11 rounds toward -infinity. Both modes increment the magnitude only when the input is inexact and the rounding direction points away from zero.
- R5: When rounding carries out of the 24-bit significand, the exponent rises by one and the fraction becomes zero.
- R6: out_inc is 1 exactly when rounding incremented the significand magnitude.
- R7: out_inexact is 1 exactly when the rounded value differs from the input integer.
- R8: out_sticky becomes 1 at the output of any valid conversion that is inexact. Only reset clears it.
- R9: out_class is 5'b00010 for +zero, 5'b00100 for a positive normal result and 5'b01000 for a negative normal result.
- R10: A zero input gives an all-zero output word with class +zero, and out_inc and out_inexact are both 0.
- R11: The most negative input, -2^63, converts exactly to a word with sign 1, biased exponent 1086 and fraction zero.
- R12: Reset sets every output to zero except out_class, which resets to +zero. out_valid equals in_valid delayed by one clock. The result, flag and class outputs hold their values through cycles when in_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | 64 | Signed integer operand |
| in_mode | input | 2 | Rounding mode: 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf |
| in_valid | input | 1 | Operand strobe |
| out_result | output | 64 | Rounded value in double-precision encoding |
| out_valid | output | 1 | Result strobe, one clock after in_valid |
| out_inc | output | 1 | Rounding incremented the significand |
| out_inexact | output | 1 | Result differs from the input |
| out_sticky | output | 1 | Accumulated inexact status |
| out_class | output | 5 | Class and sign code of the result |

## Verification
The assertions check several properties on every cycle:
- The normaliser always leaves a leading one in the top bit for a nonzero magnitude.
- An increment never occurs without inexactness, and never in truncation mode.
- The accumulated inexact bit never falls outside reset.
- A valid class code is one-hot, and a zero-class result carries no flags.
- Idle cycles leave the result unchanged.

Only the bench's scenarios can show that the rounded bits are the right ones. This covers tie-to-even decisions, the directed modes on both signs, carry-out into the exponent and the exact handling of -2^63. The bench shows this by comparing every output against an arithmetic model built from shifts and remainders.

// File: rtl/i2s_pkg.sv
package i2s_pkg;

  typedef enum logic [1:0] {
    RM_NEAREST = 2'b00,
    RM_ZERO    = 2'b01,
    RM_UP      = 2'b10,
    RM_DOWN    = 2'b11
  } rmode_e;

  localparam logic [4:0] CLS_POS_ZERO = 5'b00010;
  localparam logic [4:0] CLS_POS_NORM = 5'b00100;
  localparam logic [4:0] CLS_NEG_NORM = 5'b01000;

  // Decide whether the kept significand is bumped by one unit.
  function automatic logic round_up(rmode_e mode, logic sign, logic lsb,
                                    logic guard, logic sticky);
    logic lost;
    lost = guard | sticky;
    case (mode)
      RM_NEAREST: return guard & (sticky | lsb);
      RM_ZERO:    return 1'b0;
      RM_UP:      return lost & ~sign;
      default:    return lost & sign;
    endcase
  endfunction

  function automatic logic [4:0] class_code(logic is_zero, logic sign);
    if (is_zero) return CLS_POS_ZERO;
    return sign ? CLS_NEG_NORM : CLS_POS_NORM;
  endfunction

endpackage

// File: rtl/i2s_normalise.sv
module i2s_normalise #(
  parameter int unsigned W = 64,
  localparam int unsigned LW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  mag,
  output logic [W-1:0]  norm,
  output logic [LW-1:0] lz,
  output logic          zero
);

  assign zero = ~|mag;

  // Leading-zero count: the highest set bit wins.
  always_comb begin
    lz = '0;
    for (int i = 0; i < W; i++) begin
      if (mag[i]) lz = LW'(W - 1 - i);
    end
  end

  // Logarithmic left shifter, one stage per bit of the count.
  logic [W-1:0] stage [LW+1];
  assign stage[0] = mag;
  for (genvar s = 0; s < LW; s++) begin : g_shift
    assign stage[s+1] = lz[s] ? (stage[s] << (1 << s)) : stage[s];
  end
  assign norm = stage[LW];

  assert_norm_msb_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !zero |-> norm[W-1]);

endmodule

// File: rtl/i2s_round.sv
module i2s_round
  import i2s_pkg::*;
#(
  parameter int unsigned W     = 64,
  parameter int unsigned MAN_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     norm,
  input  logic             sign,
  input  logic             zero,
  input  rmode_e           mode,
  output logic [MAN_W-1:0] sig,
  output logic             carry,
  output logic             inc,
  output logic             inexact
);

  logic [MAN_W-1:0] keep;
  logic             guard, sticky;
  logic [MAN_W:0]   sum;

  assign keep    = norm[W-1 -: MAN_W];
  assign guard   = norm[W-1-MAN_W];
  assign sticky  = |norm[W-2-MAN_W:0];
  assign inexact = guard | sticky;
  assign inc     = round_up(mode, sign, keep[0], guard, sticky);
  assign sum     = {1'b0, keep} + {{MAN_W{1'b0}}, inc};
  assign carry   = sum[MAN_W];
  // On carry-out the significand becomes exactly 1.0.
  assign sig     = carry ? {1'b1, {(MAN_W-1){1'b0}}} : sum[MAN_W-1:0];

  assert_inc_needs_loss_R6: assert property (@(posedge clk) disable iff (!rst_n)
    inc |-> inexact);
  assert_trunc_no_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == RM_ZERO) |-> !inc);
  assert_zero_exact_R10: assert property (@(posedge clk) disable iff (!rst_n)
    zero |-> !inexact);

endmodule

// File: rtl/i2s_pack.sv
module i2s_pack
  import i2s_pkg::*;
#(
  parameter int unsigned W      = 64,
  parameter int unsigned MAN_W  = 24,
  parameter int unsigned EXP_W  = 11,
  parameter int unsigned FRAC_W = 52,
  parameter int unsigned BIAS   = 1023,
  localparam int unsigned LW    = $clog2(W),
  localparam int unsigned OUT_W = 1 + EXP_W + FRAC_W,
  localparam int unsigned PAD_W = FRAC_W - MAN_W + 1
) (
  input  logic             sign,
  input  logic             zero,
  input  logic [LW-1:0]    lz,
  input  logic             carry,
  input  logic [MAN_W-1:0] sig,
  output logic [OUT_W-1:0] word,
  output logic [4:0]       cls
);

  localparam int unsigned EXP_TOP = W - 1 + BIAS;

  logic [EXP_W-1:0]  exp_b;
  logic [FRAC_W-1:0] frac;

  assign exp_b = EXP_W'(EXP_TOP) - EXP_W'(lz) + EXP_W'(carry);
  assign frac  = {sig[MAN_W-2:0], {PAD_W{1'b0}}};
  assign word  = zero ? '0 : {sign, exp_b, frac};
  assign cls   = class_code(zero, sign);

endmodule

// File: rtl/i2s_convert.sv
module i2s_convert
  import i2s_pkg::*;
#(
  parameter int unsigned IN_W   = 64,
  parameter int unsigned MAN_W  = 24,
  parameter int unsigned EXP_W  = 11,
  parameter int unsigned FRAC_W = 52,
  parameter int unsigned BIAS   = 1023,
  localparam int unsigned LW    = $clog2(IN_W),
  localparam int unsigned OUT_W = 1 + EXP_W + FRAC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IN_W-1:0]  in_data,
  input  logic [1:0]       in_mode,
  input  logic             in_valid,
  output logic [OUT_W-1:0] out_result,
  output logic             out_valid,
  output logic             out_inc,
  output logic             out_inexact,
  output logic             out_sticky,
  output logic [4:0]       out_class
);

  logic             sign, zero, carry, inc, inexact;
  logic [IN_W-1:0]  mag, norm;
  logic [LW-1:0]    lz;
  logic [MAN_W-1:0] sig;
  logic [OUT_W-1:0] word;
  logic [4:0]       cls;

  assign sign = in_data[IN_W-1];
  assign mag  = sign ? (~in_data + IN_W'(1)) : in_data;

  i2s_normalise #(.W(IN_W)) u_norm (
    .clk(clk), .rst_n(rst_n), .mag(mag), .norm(norm), .lz(lz), .zero(zero)
  );

  i2s_round #(.W(IN_W), .MAN_W(MAN_W)) u_round (
    .clk(clk), .rst_n(rst_n), .norm(norm), .sign(sign), .zero(zero),
    .mode(rmode_e'(in_mode)), .sig(sig), .carry(carry), .inc(inc),
    .inexact(inexact)
  );

  i2s_pack #(.W(IN_W), .MAN_W(MAN_W), .EXP_W(EXP_W), .FRAC_W(FRAC_W),
             .BIAS(BIAS)) u_pack (
    .sign(sign), .zero(zero), .lz(lz), .carry(carry), .sig(sig),
    .word(word), .cls(cls)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_result  <= '0;
      out_valid   <= 1'b0;
      out_inc     <= 1'b0;
      out_inexact <= 1'b0;
      out_sticky  <= 1'b0;
      out_class   <= CLS_POS_ZERO;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result  <= word;
        out_inc     <= inc;
        out_inexact <= inexact;
        out_class   <= cls;
        if (inexact) out_sticky <= 1'b1;
      end
    end
  end

  assert_sticky_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(out_sticky));
  assert_sticky_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_inexact) |-> out_sticky);
  assert_class_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(out_class) == 1));
  assert_zero_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_class == CLS_POS_ZERO) |->
      (out_result == '0 && !out_inc && !out_inexact));
  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_result));

endmodule

// File: tb/test_i2s_convert.sv
module test_i2s_convert;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] din = '0;
  logic [1:0]  mode = '0;
  logic        vin = 1'b0;

  logic [63:0] out_result;
  logic        out_valid, out_inc, out_inexact, out_sticky;
  logic [4:0]  out_class;

  int compared = 0;
  int mismatched = 0;
  bit checking = 0;
  bit done = 0;

  always #10 clk = ~clk;

  i2s_convert i_i2s_convert (
    .clk(clk), .rst_n(rst_n), .in_data(din), .in_mode(mode), .in_valid(vin),
    .out_result(out_result), .out_valid(out_valid), .out_inc(out_inc),
    .out_inexact(out_inexact), .out_sticky(out_sticky), .out_class(out_class)
  );

  typedef struct packed {
    logic [63:0] res;
    logic        inc;
    logic        inx;
    logic [4:0]  cls;
  } exp_t;

  // Arithmetic model: find the top bit, divide by a power of two, compare remainder.
  function automatic exp_t model(logic [63:0] x, logic [1:0] m);
    exp_t r;
    logic neg;
    logic [63:0] mag, q, rem, half;
    int p, e, sh;
    logic up;
    r = '0;
    neg = x[63];
    mag = neg ? -x : x;
    if (mag == 0) begin
      r.cls = 5'b00010;
      return r;
    end
    p = 0;
    for (int i = 0; i < 64; i++) if (mag[i]) p = i;
    if (p <= 23) begin
      q = mag << (23 - p);
      rem = 0;
      half = 1;
    end else begin
      sh = p - 23;
      q = mag >> sh;
      rem = mag - (q << sh);
      half = 64'd1 << (sh - 1);
    end
    r.inx = (rem != 0);
    case (m)
      2'b00: up = (rem > half) || (rem == half && q[0]);
      2'b01: up = 1'b0;
      2'b10: up = r.inx && !neg;
      default: up = r.inx && neg;
    endcase
    q = q + 64'(up);
    e = p;
    if (q == 64'd1 << 24) begin
      q = 64'd1 << 23;
      e = p + 1;
    end
    r.inc = up;
    r.res = {neg, 11'(e + 1023), q[22:0], 29'b0};
    r.cls = neg ? 5'b01000 : 5'b00100;
    return r;
  endfunction

  // Cycle-by-cycle expected register state.
  exp_t        m_cur;
  logic        m_val, m_stk;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cur <= '{res: 64'd0, inc: 1'b0, inx: 1'b0, cls: 5'b00010};
      m_val <= 1'b0;
      m_stk <= 1'b0;
    end else begin
      m_val <= vin;
      if (vin) begin
        m_cur <= model(din, mode);
        if (model(din, mode).inx) m_stk <= 1'b1;
      end
    end
  end

  always @(negedge clk) begin
    if (checking && !done) begin
      bit bad;
      bad = 0;
      compared++;
      if (out_result !== m_cur.res) begin
        bad = 1;
        $display("FAIL R1/R2/R5 result: actual %h expected %h (in %h mode %0d)",
                 out_result, m_cur.res, din, mode);
      end
      if (out_inc !== m_cur.inc) begin
        bad = 1;
        $display("FAIL R6 inc: actual %b expected %b", out_inc, m_cur.inc);
      end
      if (out_inexact !== m_cur.inx) begin
        bad = 1;
        $display("FAIL R7 inexact: actual %b expected %b", out_inexact, m_cur.inx);
      end
      if (out_sticky !== m_stk) begin
        bad = 1;
        $display("FAIL R8 sticky: actual %b expected %b", out_sticky, m_stk);
      end
      if (out_class !== m_cur.cls) begin
        bad = 1;
        $display("FAIL R9 class: actual %b expected %b", out_class, m_cur.cls);
      end
      if (out_valid !== m_val) begin
        bad = 1;
        $display("FAIL R12 valid: actual %b expected %b", out_valid, m_val);
      end
      if (bad) mismatched++;
    end
  end

  task automatic send(input logic [63:0] v, input logic [1:0] m);
    @(negedge clk);
    din = v;
    mode = m;
    vin = 1'b1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      vin = 1'b0;
      din = {$urandom, $urandom};
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected completion");
      finish_run();
    end
  end

  initial begin
    @(posedge clk);
    checking = 1;            // R12 reset state compared from here on
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    // R10 zero, R1 exact small values, R11 most negative, all modes
    for (int m = 0; m < 4; m++) begin
      send(64'd0, 2'(m));
      send(64'd1, 2'(m));
      send(-64'd1, 2'(m));
      send(64'h0000_0000_00FF_FFFF, 2'(m));
      send(-64'h0000_0000_00FF_FFFF, 2'(m));
      send(64'h8000_0000_0000_0000, 2'(m));
      send(64'h0000_0100_0000_0000, 2'(m));
    end
    idle(3);                 // R12 hold, R8 sticky still clear
    // R2 ties: to even downward, then upward
    send(64'h0000_0000_0100_0001, 2'b00);
    send(64'h0000_0000_0100_0003, 2'b00);
    send(-64'h0000_0000_0100_0003, 2'b00);
    // R5 carry into the exponent
    send(64'h7FFF_FFFF_FFFF_FFFF, 2'b00);
    send(64'h7FFF_FFFF_FFFF_FFFF, 2'b10);
    send(64'h0000_0000_01FF_FFFF, 2'b00);
    send(-64'h0000_0000_01FF_FFFF, 2'b11);
    // R3 truncation, R4 directed modes on both signs
    for (int m = 0; m < 4; m++) begin
      send(64'h0000_0000_0100_0001, 2'(m));
      send(-64'h0000_0000_0100_0001, 2'(m));
      send(64'h0123_4567_89AB_CDEF, 2'(m));
    end
    idle(2);
    // Mixed random operands of varied magnitude, R7 and R8 along the way
    for (int i = 0; i < 3000; i++) begin
      logic [63:0] v;
      v = {$urandom, $urandom} >> ($urandom % 64);
      if ($urandom % 2) v = -v;
      if ($urandom % 7 == 0) idle(1);
      send(v, 2'($urandom % 4));
    end
    idle(3);
    finish_run();
  end

endmodule